// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status Register

This block holds the interrupt causes of a descriptor-based Ethernet DMA in one 32-bit word. The transmit and receive engines raise one-cycle event pulses. Each pulse sets a sticky flag, and software clears a flag by writing 1 to its bit. An enable mask chooses which flags feed two sticky summary bits. The normal summary collects completion-type causes and the abnormal summary collects error and stall causes. The single interrupt output is the registered OR of the two summaries.

The same word also shows live data from the engines. It mirrors the 3-bit state codes of both engines, which are read-only. When a fatal bus error event arrives, it latches three qualifier bits that describe that error. Setting the receive-done flag removes a pending early-receive flag. Each summary bit is a two-state machine. In `SUM_QUIET` an enabled cause takes it to `SUM_PENDING` (transition "raise"). A write of 1 to the summary bit takes it back to `SUM_QUIET` (transition "ack"), but only when no enabled cause remains after that write. In every other case it stays where it is (transition "hold").

Top module: `eth_dma_irq_status`

## Requirements
- R1: After reset every stored bit reads 0 and `irq_o` is 0.
- R2: An event pulse on `evt_i[k]` sets flag k, where k is one of 0–10, 13 or 14. Flag k is visible on `rd_data_o[k]` after the next clock edge and stays set until it is cleared. Events on bits 11 and 12 are ignored, and bits 11, 12 and 31:26 always read 0.
- R3: When `wr_en_i` is high, a 1 in `wr_data_i` clears the matching flag or summary bit. A 0 bit in the write has no effect.
- R4: If an event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: An event on bit 6 (receive done) clears flag 14 (early receive), even when bit 14 also has an event in that cycle.
- R6: Bit 16 (normal summary) goes to 1 in the same cycle as any flag among bits 0, 2, 6 and 14 whose enable `irq_en_i` bit is 1.
- R7: Bit 15 (abnormal summary) goes to 1 in the same cycle as any enabled flag among bits 1, 3, 4, 5, 7, 8, 9, 10 and 13.
- R8: A flag whose enable bit is 0 does not raise a summary. A write-1 to a summary bit clears it only if no enabled cause of that summary remains after the write.
- R9: An event on bit 13 (fatal bus error) latches `bus_err_qual_i` into bits 25:23. Bit 23 = 1 means the transmit engine and 0 the receive engine. Bit 24 = 1 means a read and 0 a write. Bit 25 = 1 means a descriptor access and 0 a data buffer access. The qualifier holds while flag 13 stays set and reads 0 while flag 13 is clear.
- R10: Bits 19:17 show `rx_state_i` and bits 22:20 show `tx_state_i` in the same cycle. Writes to bits 31:17 have no effect.
- R11: `irq_o` equals the OR of the two summary bits, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 15 | Event pulses, one per flag position |
| bus_err_qual_i | input | 3 | Bus-error qualifier {descriptor, read, transmit} |
| rx_state_i | input | 3 | Receive engine state code |
| tx_state_i | input | 3 | Transmit engine state code |
| irq_en_i | input | 15 | Enable for each flag into its summary |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write-1-to-clear data |
| rd_data_o | output | 32 | Register read value |
| irq_o | output | 1 | Interrupt request |

## Verification
Flags, summary bits and qualifiers change at the clock edge that samples the event or the write. They must therefore read correctly one edge after the stimulus. The state fields follow their inputs with no delay. `irq_o` trails the summaries by one more edge. The driver applies each stimulus just after a falling edge and queues the expected word together with the interrupt value. That interrupt value is taken from the summaries the model held before that edge. The monitor compares at the next falling edge, so every result is sampled exactly one rising edge after the stimulus that produced it.

// File: rtl/dmis_pkg.sv
package dmis_pkg;
    localparam int FLAG_W       = 15;
    localparam int REG_W        = 32;
    localparam int STATE_W      = 3;
    localparam int QUAL_W       = 3;
    localparam int RXDONE_BIT   = 6;
    localparam int EARLYRX_BIT  = 14;
    localparam int FATAL_BIT    = 13;
    localparam int ABN_SUM_BIT  = 15;
    localparam int NORM_SUM_BIT = 16;
    localparam int RXST_LSB     = 17;
    localparam int TXST_LSB     = RXST_LSB + STATE_W;
    localparam int QUAL_LSB     = TXST_LSB + STATE_W;
    localparam int PAD_W        = REG_W - QUAL_LSB - QUAL_W;

    localparam logic [FLAG_W-1:0] IMPL_MASK   = 15'h67FF;
    localparam logic [FLAG_W-1:0] NORM_GROUP  = 15'h4045;
    localparam logic [FLAG_W-1:0] ABN_GROUP   = 15'h27BA;

    typedef enum logic {
        SUM_QUIET   = 1'b0,
        SUM_PENDING = 1'b1
    } sum_state_t;

    typedef struct packed {
        logic desc;
        logic rd;
        logic tx;
    } berr_qual_t;
endpackage

// File: rtl/dmis_flag_bank.sv
module dmis_flag_bank #(
    parameter int             W        = 15,
    parameter logic [W-1:0]   IMPL     = '1,
    parameter int             AUTO_SRC = 6,
    parameter int             AUTO_DST = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_next_o,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flag_q;
    logic [W-1:0] flag_d;
    logic [W-1:0] kill;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == AUTO_DST) begin : g_auto
            assign kill[i] = set_i[AUTO_SRC];
        end else begin : g_plain
            assign kill[i] = 1'b0;
        end

        // set dominates clear; chained auto-clear dominates both
        assign flag_d[i] = (set_i[i] | (flag_q[i] & ~clr_i[i])) & ~kill[i] & IMPL[i];

        if (IMPL[i]) begin : g_chk
            assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[i] && !clr_i[i] && !kill[i]) |=> flag_q[i]);
            assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (set_i[i] && !kill[i]) |=> flag_q[i]);
            assert_auto_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
                kill[i] |=> !flag_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags_next_o = flag_d;
    assign flags_o      = flag_q;
endmodule

// File: rtl/dmis_summary.sv
module dmis_summary
    import dmis_pkg::*;
#(
    parameter int           W     = 15,
    parameter logic [W-1:0] GROUP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause_i,
    input  logic [W-1:0] en_i,
    input  logic         ack_i,
    output logic         sum_o
);
    sum_state_t state_q, state_d;
    logic       hit;

    assign hit = |(cause_i & en_i & GROUP);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUM_QUIET:   if (hit) state_d = SUM_PENDING;
            SUM_PENDING: if (ack_i && !hit) state_d = SUM_QUIET;
            default:     state_d = SUM_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SUM_QUIET;
        else        state_q <= state_d;
    end

    assign sum_o = (state_q == SUM_PENDING);

    assert_sum_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> sum_o);
    assert_sum_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_o && !ack_i) |=> sum_o);
    assert_sum_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sum_o && !hit) |=> !sum_o);
endmodule

// File: rtl/dmis_err_qual.sv
module dmis_err_qual #(
    parameter int QW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic          keep_i,
    input  logic [QW-1:0] qual_i,
    output logic [QW-1:0] qual_o
);
    logic [QW-1:0] qual_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         qual_q <= '0;
        else if (capture_i) qual_q <= qual_i;
        else if (!keep_i)   qual_q <= '0;
    end

    assign qual_o = qual_q;

    assert_qual_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (qual_o == $past(qual_i)));
    assert_qual_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!keep_i && !capture_i) |=> (qual_o == '0));
    assert_qual_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_i && !capture_i) |=> $stable(qual_o));
endmodule

// File: rtl/eth_dma_irq_status.sv
module eth_dma_irq_status
    import dmis_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FLAG_W-1:0]   evt_i,
    input  logic [QUAL_W-1:0]   bus_err_qual_i,
    input  logic [STATE_W-1:0]  rx_state_i,
    input  logic [STATE_W-1:0]  tx_state_i,
    input  logic [FLAG_W-1:0]   irq_en_i,
    input  logic                wr_en_i,
    input  logic [REG_W-1:0]    wr_data_i,
    output logic [REG_W-1:0]    rd_data_o,
    output logic                irq_o
);
    logic [REG_W-1:0]  clr;
    logic [FLAG_W-1:0] flags_d, flags_q;
    logic              sum_norm, sum_abn;
    berr_qual_t        qual;
    logic              irq_q;
    logic              unused_wr_hi;

    assign clr          = wr_en_i ? wr_data_i : '0;
    assign unused_wr_hi = ^clr[REG_W-1:NORM_SUM_BIT+1];

    dmis_flag_bank #(
        .W(FLAG_W), .IMPL(IMPL_MASK), .AUTO_SRC(RXDONE_BIT), .AUTO_DST(EARLYRX_BIT)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr[FLAG_W-1:0]),
        .flags_next_o(flags_d), .flags_o(flags_q)
    );

    dmis_summary #(.W(FLAG_W), .GROUP(NORM_GROUP)) u_sum_norm (
        .clk(clk), .rst_n(rst_n), .cause_i(flags_d), .en_i(irq_en_i),
        .ack_i(clr[NORM_SUM_BIT]), .sum_o(sum_norm)
    );

    dmis_summary #(.W(FLAG_W), .GROUP(ABN_GROUP)) u_sum_abn (
        .clk(clk), .rst_n(rst_n), .cause_i(flags_d), .en_i(irq_en_i),
        .ack_i(clr[ABN_SUM_BIT]), .sum_o(sum_abn)
    );

    dmis_err_qual #(.QW(QUAL_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .capture_i(evt_i[FATAL_BIT]),
        .keep_i(flags_d[FATAL_BIT]), .qual_i(bus_err_qual_i), .qual_o(qual)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= sum_norm | sum_abn;
    end

    assign irq_o     = irq_q;
    assign rd_data_o = {{PAD_W{1'b0}}, qual, tx_state_i, rx_state_i, sum_norm, sum_abn, flags_q};

    assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(sum_norm | sum_abn)));
    assert_qual_needs_fatal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_q[FATAL_BIT] |-> (qual == '0));
endmodule

// File: tb/sim_eth_dma_irq_status.sv
module sim_eth_dma_irq_status;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] evt = '0;
    logic [2:0]  qual_in = '0, rxs = '0, txs = '0;
    logic [14:0] en = '0;
    logic        wr = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [14:0] m_fl = '0;
    logic        m_sn = 1'b0, m_sa = 1'b0;
    logic [2:0]  m_q = '0;

    always #HALF clk = ~clk;

    eth_dma_irq_status u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_err_qual_i(qual_in),
        .rx_state_i(rxs), .tx_state_i(txs), .irq_en_i(en), .wr_en_i(wr),
        .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares one rising edge after each stimulus
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(rd === e.rd, e.tag, rd, e.rd);
            chk(irq === e.irq, {e.tag, " R11 irq"}, {31'b0, irq}, {31'b0, e.irq});
        end
    end

    // driver: applies stimulus after the falling edge and queues the expected result
    task automatic cyc(input logic [14:0] ev, input bit w, input logic [31:0] d,
                       input logic [14:0] e, input logic [2:0] r, input logic [2:0] t,
                       input logic [2:0] qv, input string tag);
        logic [31:0] c;
        logic [14:0] nf;
        logic        nsn, nsa;
        logic [2:0]  nq;
        exp_t        x;
        @(negedge clk);
        #2;
        evt = ev; wr = w; wd = d; en = e; rxs = r; txs = t; qual_in = qv;
        c   = w ? d : 32'h0;
        nf  = (ev | (m_fl & ~c[14:0])) & 15'h67FF;
        if (ev[6]) nf[14] = 1'b0;
        nsn = (m_sn & ~c[16]) | (|(nf & e & 15'h4045));
        nsa = (m_sa & ~c[15]) | (|(nf & e & 15'h27BA));
        nq  = ev[13] ? qv : (nf[13] ? m_q : 3'b000);
        x.irq = m_sn | m_sa;
        x.rd  = {6'b0, nq, t, r, nsn, nsa, nf};
        x.tag = tag;
        sb.push_back(x);
        m_fl = nf; m_sn = nsn; m_sa = nsa; m_q = nq;
    endtask

    localparam logic [14:0] ALL = 15'h7FFF;

    initial begin : watchdog
        #(2 * HALF * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk(rd === 32'h0 && irq === 1'b0, "R1 in reset", rd, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc('0, 0, '0, ALL, 0, 0, 0, "R1 after reset");
        // R2 R6 transmit done sets flag and normal summary
        cyc(15'h0001, 0, '0, ALL, 0, 0, 0, "R2 R6 set bit0");
        cyc('0, 0, '0, ALL, 0, 0, 0, "R2 sticky");
        cyc('0, 1, 32'h0, ALL, 0, 0, 0, "R3 write zeros");
        cyc('0, 1, 32'h0001_0001, ALL, 0, 0, 0, "R3 clear flag and summary");
        cyc('0, 0, '0, ALL, 0, 0, 0, "R11 irq drops");
        // R8 summary ack while cause remains
        cyc(15'h0004, 0, '0, ALL, 0, 0, 0, "R6 bit2");
        cyc('0, 1, 32'h0001_0000, ALL, 0, 0, 0, "R8 ack held by cause");
        cyc('0, 1, 32'h0001_0004, ALL, 0, 0, 0, "R8 ack with cause cleared");
        // R4 set beats clear
        cyc(15'h0001, 1, 32'h0000_0001, ALL, 0, 0, 0, "R4 set wins");
        cyc('0, 1, 32'h0001_0001, ALL, 0, 0, 0, "R3 cleanup");
        // R5 receive done removes early receive
        cyc(15'h4000, 0, '0, ALL, 0, 0, 0, "R6 early rx");
        cyc(15'h0040, 0, '0, ALL, 0, 0, 0, "R5 rx done clears early");
        cyc('0, 1, 32'hFFFF_FFFF, ALL, 0, 0, 0, "R3 clear all");
        cyc(15'h4040, 0, '0, ALL, 0, 0, 0, "R5 both same cycle");
        cyc('0, 1, 32'hFFFF_FFFF, ALL, 0, 0, 0, "R3 clear all");
        // R7 R8 masking
        cyc(15'h0008, 0, '0, 15'h0010, 0, 0, 0, "R8 masked jabber");
        cyc(15'h0010, 0, '0, 15'h0010, 0, 0, 0, "R7 enabled overflow");
        cyc('0, 1, 32'h0000_8018, 15'h0010, 0, 0, 0, "R3 clear abnormal");
        cyc(15'h27BA, 0, '0, ALL, 0, 0, 0, "R7 all abnormal causes");
        cyc('0, 1, 32'hFFFF_FFFF, ALL, 0, 0, 0, "R3 clear all");
        cyc(15'h4045, 0, '0, ALL, 0, 0, 0, "R6 all normal causes");
        cyc('0, 1, 32'hFFFF_FFFF, ALL, 0, 0, 0, "R3 clear all");
        // R9 bus error qualifiers
        cyc(15'h2000, 0, '0, ALL, 0, 0, 3'b101, "R9 capture");
        cyc('0, 0, '0, ALL, 0, 0, 3'b010, "R9 held");
        cyc(15'h2000, 0, '0, ALL, 0, 0, 3'b011, "R9 recapture");
        cyc('0, 1, 32'h0000_A000, ALL, 0, 0, 3'b111, "R9 cleared with fatal");
        // R10 state mirror and read-only fields
        cyc('0, 0, '0, ALL, 3'b011, 3'b110, 0, "R10 state mirror");
        cyc('0, 1, 32'hFFFE_0000, ALL, 3'b100, 3'b001, 0, "R10 write ro fields");
        // R2 unimplemented positions
        cyc(15'h1800, 0, '0, ALL, 0, 0, 0, "R2 bits 11 12 ignored");
        cyc('0, 0, '0, ALL, 0, 0, 0, "R2 idle");
        cyc('0, 0, '0, ALL, 0, 0, 0, "R11 idle");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule